// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It divides the incoming oscillator clock by four to make a count clock. It then repeats a four-phase measurement cycle: clear the integrator, auto-zero, integrate the signal, and de-integrate against the reference. In each phase it drives one analog switch-control line. It samples two comparator outputs: a sign bit that says the integrator sits above zero, and a null flag that says the integrator is inside its zero band.

The time taken to de-integrate is counted directly in decimal. When de-integration ends, the count is latched into a result register as three BCD digits, a thousands bit, a sign and an over-range flag. The integrator-clear phase adapts its length to the comparator. The auto-zero phase then absorbs whatever time is left. As a result, the interval from the end of one signal integration to the end of the next is always 4000 counts, whatever the input.

Top module: `dslope_seq`

## Requirements
- R1: Every phase change and every result update happens on a count clock, which is one oscillator clock in four, so each phase lasts a whole multiple of four oscillator clocks.
- R2: The `phase` output steps only forward through 0 (integrator clear), 1 (auto-zero), 2 (signal integrate), 3 (de-integrate) and back to 0. Exactly one of the five switch lines is high: `sw_zero_int` in phase 0, `sw_auto_zero` in 1, `sw_sig_int` in 2, and `sw_ref_pos` or `sw_ref_neg` in 3.
- R3: Signal integrate always lasts 1000 counts. The sign is taken from `cmp_pos` on its last count.
- R4: De-integrate ends on the first count where `cmp_pos` differs from the captured sign. The number of counts completed before that count is the reading, presented as `rd_thou` plus BCD `rd_hund`, `rd_tens` and `rd_units`.
- R5: If no crossing is seen within 2000 counts, de-integrate stops and sets `rd_ovr`. In that case `rd_thou` reads 1 and the three BCD digits read 0.
- R6: Integrator clear ends on the first count number n (counting from 1) with `cmp_null` high and n at least 11, or at 140 at the latest. After an over-range conversion, the limits become 31 and 640.
- R7: Auto-zero lasts 3000 counts minus the previous de-integrate length minus the clear length. The interval between successive rises of `cycle_done` is therefore always 16000 oscillator clocks.
- R8: The result outputs change only at the end of de-integrate and hold through the following cycle.
- R9: `cycle_done` rises when signal integration ends and stays high for exactly one count (four oscillator clocks).
- R10: `rd_neg` is 1 when `cmp_pos` was low at the end of signal integration, even when the reading is zero.
- R11: After reset, `phase` is 0, all result outputs and `cycle_done` are 0, and `sw_zero_int` is high.
- R12: During de-integrate, `sw_ref_neg` is high for a positive captured sign and `sw_ref_pos` for a negative one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_pos | input | 1 | Comparator: integrator output above zero |
| cmp_null | input | 1 | Comparator: integrator output inside zero band |
| phase | output | 2 | Current phase code (0 clear, 1 auto-zero, 2 integrate, 3 de-integrate) |
| count_tick | output | 1 | Count-clock enable, one oscillator clock in four |
| sw_zero_int | output | 1 | Integrator clear switch |
| sw_auto_zero | output | 1 | Auto-zero loop switch |
| sw_sig_int | output | 1 | Input-to-integrator switch |
| sw_ref_pos | output | 1 | Reference applied with positive sense |
| sw_ref_neg | output | 1 | Reference applied with negative sense |
| rd_units | output | 4 | Reading, units digit (BCD) |
| rd_tens | output | 4 | Reading, tens digit (BCD) |
| rd_hund | output | 4 | Reading, hundreds digit (BCD) |
| rd_thou | output | 1 | Reading, thousands bit |
| rd_neg | output | 1 | Reading is negative |
| rd_ovr | output | 1 | Reading is over range |
| cycle_done | output | 1 | One-count pulse at the end of signal integration |

## Verification
A behavioural integrator model flips `cmp_pos` after a chosen number of de-integrate counts and raises `cmp_null` after a chosen number of clear counts. A table of eight conversions varies sign, crossing count and null delay.

The crossing counts probe three separate behaviours:
- A mid-scale value and the exact full scale of 1999 confirm the decimal count.
- A crossing at 2000 and one at 2500 both confirm the cap and the over-range flag.
- A crossing at zero with a negative sign confirms that the sign survives a zero reading.

The null delays cover three cases in turn:
- a delay inside the allowed window;
- one below the minimum;
- one beyond the maximum, after both in-range and over-range conversions.

This separates the four clear-length limits from each other. Because the input changes from one conversion to the next, a constant `cycle_done` period shows that auto-zero compensates for the previous de-integrate length.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

   typedef enum logic [1:0] {
      PH_ZERO  = 2'd0,
      PH_AUTOZ = 2'd1,
      PH_SIGIN = 2'd2,
      PH_DEINT = 2'd3
   } dslope_phase_e;

endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
         if (!rst_n)             pre_q <= '0;
         else if (pre_q == LAST) pre_q <= '0;
         else                    pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == LAST);
   end
endmodule

// File: rtl/dslope_bcd_count.sv
module dslope_bcd_count #(
   parameter int DIGITS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   inc,
   output logic [DIGITS-1:0][3:0] dig
);
   logic [DIGITS:0] carry;
   assign carry[0] = inc;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] d_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clr)   d_q <= 4'd0;
         else if (carry[i])   d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
      end

      assign carry[i+1] = carry[i] && (d_q == 4'd9);
      assign dig[i]     = d_q;
   end
endmodule

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
   import dslope_pkg::*;
#(
   parameter int FRAME_COUNTS = 4000,
   parameter int INT_COUNTS   = 1000,
   parameter int DE_MAX       = 2000,
   parameter int ZI_MIN_OK    = 11,
   parameter int ZI_MAX_OK    = 140,
   parameter int ZI_MIN_OVR   = 31,
   parameter int ZI_MAX_OVR   = 640
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          cmp_pos,
   input  logic          cmp_null,
   output dslope_phase_e phase,
   output logic          pol_pos,
   output logic          bcd_clr,
   output logic          bcd_inc,
   output logic          de_end,
   output logic          de_ovr,
   output logic          cycle_done
);
   localparam int CW = $clog2(FRAME_COUNTS + 1);
   localparam logic [CW-1:0] FRAME_C = CW'(FRAME_COUNTS);
   localparam logic [CW-1:0] INT_C   = CW'(INT_COUNTS);
   localparam logic [CW-1:0] DEMAX_C = CW'(DE_MAX);
   localparam logic [CW-1:0] ZLO_N   = CW'(ZI_MIN_OK);
   localparam logic [CW-1:0] ZHI_N   = CW'(ZI_MAX_OK);
   localparam logic [CW-1:0] ZLO_O   = CW'(ZI_MIN_OVR);
   localparam logic [CW-1:0] ZHI_O   = CW'(ZI_MAX_OVR);

   dslope_phase_e ph_q;
   logic [CW-1:0] cnt_q, de_len_q, zi_len_q;
   logic          ovr_last_q, pol_q, done_q;

   logic [CW-1:0] cnt_inc, zi_lo, zi_hi, az_len;
   logic          crossing, last;

   always_comb begin
      cnt_inc  = cnt_q + 1'b1;
      zi_lo    = ovr_last_q ? ZLO_O : ZLO_N;
      zi_hi    = ovr_last_q ? ZHI_O : ZHI_N;
      crossing = (cmp_pos != pol_q);
      az_len   = FRAME_C - INT_C - de_len_q - zi_len_q;
      unique case (ph_q)
         PH_ZERO:  last = (cmp_null && (cnt_inc >= zi_lo)) || (cnt_inc >= zi_hi);
         PH_AUTOZ: last = (cnt_inc >= az_len);
         PH_SIGIN: last = (cnt_inc >= INT_C);
         PH_DEINT: last = crossing || (cnt_inc >= DEMAX_C);
         default:  last = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= PH_ZERO;
         cnt_q      <= '0;
         de_len_q   <= '0;
         zi_len_q   <= '0;
         ovr_last_q <= 1'b0;
         pol_q      <= 1'b0;
         done_q     <= 1'b0;
      end else if (tick) begin
         done_q <= (ph_q == PH_SIGIN) && last;
         if (last) begin
            cnt_q <= '0;
            unique case (ph_q)
               PH_ZERO: begin
                  zi_len_q <= cnt_inc;
                  ph_q     <= PH_AUTOZ;
               end
               PH_AUTOZ: ph_q <= PH_SIGIN;
               PH_SIGIN: begin
                  pol_q <= cmp_pos;
                  ph_q  <= PH_DEINT;
               end
               default: begin
                  de_len_q   <= cnt_inc;
                  ovr_last_q <= !crossing;
                  ph_q       <= PH_ZERO;
               end
            endcase
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end

   assign phase      = ph_q;
   assign pol_pos    = pol_q;
   assign bcd_clr    = tick && (ph_q == PH_SIGIN) && last;
   assign bcd_inc    = tick && (ph_q == PH_DEINT) && !last;
   assign de_end     = tick && (ph_q == PH_DEINT) && last;
   assign de_ovr     = !crossing;
   assign cycle_done = done_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dslope_pkg::*;
#(
   parameter int DIV          = 4,
   parameter int FRAME_COUNTS = 4000,
   parameter int INT_COUNTS   = 1000,
   parameter int DE_MAX       = 2000,
   parameter int ZI_MIN_OK    = 11,
   parameter int ZI_MAX_OK    = 140,
   parameter int ZI_MIN_OVR   = 31,
   parameter int ZI_MAX_OVR   = 640
) (
   input  logic       clk_osc,
   input  logic       rst_n,
   input  logic       cmp_pos,
   input  logic       cmp_null,
   output logic [1:0] phase,
   output logic       count_tick,
   output logic       sw_zero_int,
   output logic       sw_auto_zero,
   output logic       sw_sig_int,
   output logic       sw_ref_pos,
   output logic       sw_ref_neg,
   output logic [3:0] rd_units,
   output logic [3:0] rd_tens,
   output logic [3:0] rd_hund,
   output logic       rd_thou,
   output logic       rd_neg,
   output logic       rd_ovr,
   output logic       cycle_done
);
   localparam int NDIG = 4;

   if (FRAME_COUNTS < INT_COUNTS + DE_MAX + ZI_MAX_OVR + 1) begin : g_bad_budget
      $error("dslope_seq: frame too short for worst-case phases");
   end
   if (DE_MAX > 2000 || DE_MAX < 1) begin : g_bad_cap
      $error("dslope_seq: de-integrate cap must fit the 3.5-digit reading");
   end
   if (ZI_MIN_OK > ZI_MAX_OK || ZI_MIN_OVR > ZI_MAX_OVR || ZI_MIN_OK < 1) begin : g_bad_zi
      $error("dslope_seq: integrator-clear limits inconsistent");
   end

   logic                 tick;
   dslope_phase_e        ph;
   logic                 pol_pos, bcd_clr, bcd_inc, de_end, de_ovr;
   logic [NDIG-1:0][3:0] bcd;

   dslope_prescale #(.DIV(DIV)) u_pre (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dslope_phase_ctrl #(
      .FRAME_COUNTS (FRAME_COUNTS),
      .INT_COUNTS   (INT_COUNTS),
      .DE_MAX       (DE_MAX),
      .ZI_MIN_OK    (ZI_MIN_OK),
      .ZI_MAX_OK    (ZI_MAX_OK),
      .ZI_MIN_OVR   (ZI_MIN_OVR),
      .ZI_MAX_OVR   (ZI_MAX_OVR)
   ) u_ctl (
      .clk        (clk_osc),
      .rst_n      (rst_n),
      .tick       (tick),
      .cmp_pos    (cmp_pos),
      .cmp_null   (cmp_null),
      .phase      (ph),
      .pol_pos    (pol_pos),
      .bcd_clr    (bcd_clr),
      .bcd_inc    (bcd_inc),
      .de_end     (de_end),
      .de_ovr     (de_ovr),
      .cycle_done (cycle_done)
   );

   dslope_bcd_count #(.DIGITS(NDIG)) u_bcd (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .clr   (bcd_clr),
      .inc   (bcd_inc),
      .dig   (bcd)
   );

   // Result register: written once per conversion, at the end of de-integrate
   always_ff @(posedge clk_osc) begin
      if (!rst_n) begin
         rd_units <= 4'd0;
         rd_tens  <= 4'd0;
         rd_hund  <= 4'd0;
         rd_thou  <= 1'b0;
         rd_neg   <= 1'b0;
         rd_ovr   <= 1'b0;
      end else if (de_end) begin
         rd_units <= de_ovr ? 4'd0 : bcd[0];
         rd_tens  <= de_ovr ? 4'd0 : bcd[1];
         rd_hund  <= de_ovr ? 4'd0 : bcd[2];
         rd_thou  <= de_ovr || (bcd[3] != 4'd0);
         rd_neg   <= !pol_pos;
         rd_ovr   <= de_ovr;
      end
   end

   assign phase        = ph;
   assign count_tick   = tick;
   assign sw_zero_int  = (ph == PH_ZERO);
   assign sw_auto_zero = (ph == PH_AUTOZ);
   assign sw_sig_int   = (ph == PH_SIGIN);
   assign sw_ref_neg   = (ph == PH_DEINT) && pol_pos;
   assign sw_ref_pos   = (ph == PH_DEINT) && !pol_pos;
endmodule

// File: rtl/dslope_seq_checker.sv
module dslope_seq_checker #(
   parameter int DIV        = 4,
   parameter int INT_COUNTS = 1000
) (
   input logic       clk_osc,
   input logic       rst_n,
   input logic [1:0] phase,
   input logic       count_tick,
   input logic       sw_zero_int,
   input logic       sw_auto_zero,
   input logic       sw_sig_int,
   input logic       sw_ref_pos,
   input logic       sw_ref_neg,
   input logic [3:0] rd_units,
   input logic [3:0] rd_tens,
   input logic [3:0] rd_hund,
   input logic       rd_thou,
   input logic       rd_ovr,
   input logic       cycle_done
);
   int int_cnt;

   always_ff @(posedge clk_osc) begin
      if (!rst_n)                 int_cnt <= 0;
      else if (phase != 2'd2)     int_cnt <= 0;
      else if (count_tick)        int_cnt <= int_cnt + 1;
   end

   assert_tick_gap_R1: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (count_tick && DIV > 1) |=> !count_tick);

   assert_phase_on_tick_R1: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !$stable(phase) |-> $past(count_tick));

   assert_phase_order_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !$stable(phase) |-> (phase == 2'($past(phase) + 2'd1)));

   assert_one_switch_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $countones({sw_zero_int, sw_auto_zero, sw_sig_int, sw_ref_pos, sw_ref_neg}) == 1);

   assert_int_end_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (phase == 2'd2 && count_tick && int_cnt == INT_COUNTS - 1) |=> (phase == 2'd3));

   assert_int_hold_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (phase == 2'd2 && count_tick && int_cnt < INT_COUNTS - 1) |=> (phase == 2'd2));

   assert_ovr_digits_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
      rd_ovr |-> (rd_thou && rd_units == 4'd0 && rd_tens == 4'd0 && rd_hund == 4'd0));

   assert_result_hold_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !$stable({rd_units, rd_tens, rd_hund, rd_thou, rd_ovr})
         |-> ($past(phase) == 2'd3 && phase == 2'd0));

   assert_done_in_de_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
      cycle_done |-> (phase == 2'd3));

   assert_done_rise_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $rose(cycle_done) |-> ($past(phase) == 2'd2));
endmodule

bind dslope_seq dslope_seq_checker u_dslope_seq_checker (
   .clk_osc      (clk_osc),
   .rst_n        (rst_n),
   .phase        (phase),
   .count_tick   (count_tick),
   .sw_zero_int  (sw_zero_int),
   .sw_auto_zero (sw_auto_zero),
   .sw_sig_int   (sw_sig_int),
   .sw_ref_pos   (sw_ref_pos),
   .sw_ref_neg   (sw_ref_neg),
   .rd_units     (rd_units),
   .rd_tens      (rd_tens),
   .rd_hund      (rd_hund),
   .rd_thou      (rd_thou),
   .rd_ovr       (rd_ovr),
   .cycle_done   (cycle_done)
);

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_pos, cmp_null;
   logic [1:0] phase;
   logic       count_tick, sw_zero_int, sw_auto_zero, sw_sig_int, sw_ref_pos, sw_ref_neg;
   logic [3:0] rd_units, rd_tens, rd_hund;
   logic       rd_thou, rd_neg, rd_ovr, cycle_done;

   always #5 clk = ~clk;

   dslope_seq u_dslope_seq (
      .clk_osc(clk), .rst_n(rst_n), .cmp_pos(cmp_pos), .cmp_null(cmp_null),
      .phase(phase), .count_tick(count_tick),
      .sw_zero_int(sw_zero_int), .sw_auto_zero(sw_auto_zero), .sw_sig_int(sw_sig_int),
      .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg),
      .rd_units(rd_units), .rd_tens(rd_tens), .rd_hund(rd_hund), .rd_thou(rd_thou),
      .rd_neg(rd_neg), .rd_ovr(rd_ovr), .cycle_done(cycle_done)
   );

   // stimulus / expected vectors: sign, crossing count, null delay,
   // expected reading (thousands in bit 12), negative, over-range, clear length
   localparam int NV = 8;
   localparam int T_POS  [NV] = '{1, 0, 1, 0, 1, 0, 1, 1};
   localparam int T_K    [NV] = '{1234, 567, 2500, 0, 1999, 2000, 9, 0};
   localparam int T_Z    [NV] = '{0, 50, 0, 0, 500, 5, 1000, 35};
   localparam int T_RD   [NV] = '{'h1234, 'h0567, 'h1000, 'h0000, 'h1999, 'h1000, 'h0009, 'h0000};
   localparam int T_NEG  [NV] = '{0, 1, 0, 1, 0, 1, 0, 0};
   localparam int T_OVR  [NV] = '{0, 0, 1, 0, 0, 1, 0, 0};
   localparam int T_ZI   [NV] = '{11, 51, 11, 31, 140, 11, 640, 36};

   int  n_checks = 0, n_errors = 0;
   logic pol = 1'b1;
   int  k_cross = 0, z_null = 0;
   int  de_seen = 0, zi_seen = 0;
   bit  finished = 0;

   // behavioural integrator and comparator
   always @(posedge clk) begin
      if (phase != 2'd3)   de_seen <= 0;
      else if (count_tick) de_seen <= de_seen + 1;
      if (phase != 2'd0)   zi_seen <= 0;
      else if (count_tick) zi_seen <= zi_seen + 1;
   end
   assign cmp_pos  = (phase == 2'd3 && de_seen >= k_cross) ? ~pol : pol;
   assign cmp_null = (phase == 2'd0 && zi_seen >= z_null);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // timing monitor
   int  clk_n = 0, zi_run = 0, zi_last = 0, int_run = 0, last_rise = 0, done_w = 0, periods = 0;
   logic [1:0] ph_prev = 2'd0;
   logic       done_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         clk_n++;
         if (phase != ph_prev)
            check(phase == 2'(ph_prev + 2'd1), "R2 phase order", phase, 2'(ph_prev + 2'd1));
         if (phase == 2'd0) zi_run++;
         else if (ph_prev == 2'd0) begin zi_last = zi_run; zi_run = 0; end
         if (phase == 2'd2) int_run++;
         else if (ph_prev == 2'd2) begin
            check(int_run == 4000, "R3 integrate length", int_run, 4000);
            int_run = 0;
         end
         if (cycle_done && !done_prev) begin
            if (last_rise > 0) begin
               check(clk_n - last_rise == 16000, "R7 frame period", clk_n - last_rise, 16000);
               periods++;
            end
            last_rise = clk_n;
            done_w = 0;
         end
         if (cycle_done) done_w++;
         else if (done_prev) check(done_w == 4, "R9 done width", done_w, 4);
         ph_prev   = phase;
         done_prev = cycle_done;
      end
   end

   task automatic wait_phase(input logic [1:0] p);
      do @(negedge clk); while (phase != p);
   endtask

   function automatic int reading();
      return {19'd0, rd_thou, rd_hund, rd_tens, rd_units};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #(190000 * 10);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      pol = T_POS[0] != 0; k_cross = T_K[0]; z_null = T_Z[0];
      repeat (5) @(negedge clk);
      // R11 reset state
      check(phase == 2'd0 && sw_zero_int, "R11 reset phase", phase, 0);
      check(reading() == 0 && !rd_neg && !rd_ovr && !cycle_done, "R11 reset result", reading(), 0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         wait_phase(2'd3);
         check(sw_ref_neg == (T_POS[i] != 0) && sw_ref_pos == (T_POS[i] == 0),
               "R12 reference sense", {sw_ref_pos, sw_ref_neg}, T_POS[i] != 0 ? 1 : 2);
         if (i > 0)
            check(reading() == T_RD[i-1], "R8 result held", reading(), T_RD[i-1]);
         wait_phase(2'd0);
         check(reading() == T_RD[i], "R4 R5 reading", reading(), T_RD[i]);
         check(rd_neg == (T_NEG[i] != 0), "R3 R10 sign", rd_neg, T_NEG[i]);
         check(rd_ovr == (T_OVR[i] != 0), "R5 over-range", rd_ovr, T_OVR[i]);
         if (i > 0) begin
            check(zi_last == 4 * T_ZI[i], "R6 clear length", zi_last, 4 * T_ZI[i]);
            check(zi_last % 4 == 0, "R1 count granularity", zi_last % 4, 0);
         end
         if (i + 1 < NV) begin
            pol = T_POS[i+1] != 0; k_cross = T_K[i+1]; z_null = T_Z[i+1];
         end
      end
      check(periods >= 6, "R7 periods observed", periods, 6);
      finish_run();
   end
endmodule